// File: doc/BRIEF.md
# SD/MMC Command Path Controller

This block is the command channel of a memory-card host. Software loads a 32-bit argument and then writes a command word. If that word has its go bit set, the block shifts a 48-bit command frame onto the card's CMD line, one bit for each card-clock tick. The frame carries a CRC7 that the block computes.

After the end bit the block releases the line. If the command asked for a reply, the block hunts for the card's start bit and shifts in either a 48-bit short reply or a 136-bit long reply. It checks the CRC of the reply and stores the payload in four response words.

Every outcome is recorded in a sticky status word that software clears by writing ones. Card-clock generation is not part of this block: `card_tick` is a one-cycle enable per card clock, supplied from outside. The pad is modelled as an output, an output enable and an input.

Top module: `sdc_cmd_engine`

## Requirements
- R1: After reset the status word and all four response words read 0, `cmd_oe` is 0 and `cmd_out` is 1.
- R2: A launched command puts 48 bits on `cmd_out`, MSB first, one bit per `card_tick`. The bits are: 0, then 1, then the 6-bit index, then the 32-bit argument, then CRC7, then a final 1. The CRC7 uses x^7+x^3+1, starts from zero and covers the first 40 bits of the frame.
- R3: The command word is written at address 1 with this layout: [5:0] index, [6] expect reply, [7] long reply, [8] go. A write with go at 0 sends nothing. The argument is the value most recently written at address 0.
- R4: A command with bit 6 at 0 sets status bit 0 (sent) once the end bit has gone out. This holds whatever bit 7 is set to.
- R5: A short reply is 48 bits. Frame bits [39:8] go into response word 0 (read address 4), and the other words keep their values. If the CRC7 over frame bits [47:8] equals bits [7:1], status bit 1 (reply done) is set.
- R6: A long reply is 136 bits. Its last 128 bits are stored most significant word first, in read addresses 4 to 7. The CRC7 over frame bits [127:8] is compared with bits [7:1].
- R7: The block samples the line on each tick after it releases it. If the card's start bit (0) has not appeared within 64 samples, status bit 2 (timeout) is set, no response word changes and the command ends. A start bit on the 64th sample is still accepted.
- R8: A CRC7 mismatch sets status bit 3 (CRC fail) instead of bit 1, for short and long replies alike. The received words are still stored.
- R9: Status bits stay set until a 1 is written to the same bit at address 2. A 0 written at address 2 leaves that bit unchanged.
- R10: A command-word write made while a command is in progress is ignored. It neither alters the frame being sent nor starts a second one.
- R11: `cmd_oe` is high only while the 48 command bits are being driven. The line is released from the tick after the end bit onwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| card_tick | input | 1 | One-cycle enable, one per card-clock period |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Write address: 0 argument, 1 command, 2 status clear |
| reg_wdata | input | 32 | Write data |
| rd_addr | input | 3 | Read address: 2 status, 4..7 response words |
| rd_data | output | 32 | Registered read data, one cycle after `rd_addr` |
| cmd_out | output | 1 | Value driven on the CMD line |
| cmd_oe | output | 1 | Drive enable for the CMD line |
| cmd_in | input | 1 | Sampled level of the CMD line |

## Verification
The assertions assume that `card_tick` is a single-cycle pulse and that the card drives the line only while `cmd_oe` is low. They also assume that software writes the command word only to launch a command or, deliberately, as an ignored write during a busy period. The bench card model follows these rules. It waits until the block releases the line before it drives a reply, and it starts the reply a chosen number of ticks later, up to the timeout and one past it. Ticks arrive every third clock, and register writes are placed between ticks.

// File: rtl/sdc_cmd_pkg.sv
package sdc_cmd_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_ARG  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CMD  = 3'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd2;
  localparam logic [ADDR_W-1:0] A_RSP0 = 3'd4;

  localparam int NFLAG  = 4;
  localparam int F_SENT = 0;
  localparam int F_REND = 1;
  localparam int F_TMO  = 2;
  localparam int F_CRC  = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_RESP} seq_st_t;
endpackage

// File: rtl/sdc_crc7.sv
module sdc_crc7 (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       upd,
  input  logic       shift,
  input  logic       din,
  output logic [6:0] crc
);
  logic fb;
  assign fb = crc[6] ^ din;

  always_ff @(posedge clk) begin
    if (rst || clr)
      crc <= '0;
    else if (upd)
      crc <= {crc[5:0], 1'b0} ^ ({7{fb}} & 7'h09);
    else if (shift)
      crc <= {crc[5:0], 1'b0};
  end
endmodule

// File: rtl/sdc_cmd_tx.sv
module sdc_cmd_tx #(
  parameter int HDR_W = 40
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             start,
  input  logic [HDR_W-1:0] hdr,
  output logic             line_out,
  output logic             line_oe,
  output logic             done
);
  localparam int FRAME_W = HDR_W + 8;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic             busy;
  logic [CNT_W-1:0] cnt;
  logic [HDR_W-1:0] sr;
  logic [6:0]       crc;
  logic             in_hdr, in_crc, step;

  assign in_hdr = cnt < CNT_W'(HDR_W);
  assign in_crc = (cnt >= CNT_W'(HDR_W)) && (cnt < CNT_W'(FRAME_W - 1));
  assign step   = tick && busy && (cnt != CNT_W'(FRAME_W));

  sdc_crc7 i_crc (
    .clk   (clk),
    .rst   (rst),
    .clr   (start),
    .upd   (step && in_hdr),
    .shift (step && in_crc),
    .din   (sr[HDR_W-1]),
    .crc   (crc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      cnt      <= '0;
      sr       <= '0;
      line_out <= 1'b1;
      line_oe  <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        cnt  <= '0;
        sr   <= hdr;
      end else if (tick && busy) begin
        if (cnt == CNT_W'(FRAME_W)) begin
          busy     <= 1'b0;
          line_oe  <= 1'b0;
          line_out <= 1'b1;
          done     <= 1'b1;
        end else begin
          line_oe  <= 1'b1;
          line_out <= in_hdr ? sr[HDR_W-1] : (in_crc ? crc[6] : 1'b1);
          sr       <= {sr[HDR_W-2:0], 1'b0};
          cnt      <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sdc_cmd_rx.sv
module sdc_cmd_rx #(
  parameter int DATA_W  = 32,
  parameter int WORDS   = 4,
  parameter int HDR_W   = 40,
  parameter int TIMEOUT = 64
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tick,
  input  logic                    arm,
  input  logic                    long_mode,
  input  logic                    line_in,
  output logic                    done_ok,
  output logic                    done_crc,
  output logic                    done_tmo,
  output logic [WORDS*DATA_W-1:0] frame
);
  localparam int SR_W      = WORDS * DATA_W;
  localparam int SHORT_LEN = HDR_W + 8;
  localparam int LONG_LEN  = SR_W + 8;
  localparam int CNT_W     = $clog2(LONG_LEN + 1);
  localparam int TO_W      = $clog2(TIMEOUT + 1);

  typedef enum logic [1:0] {RX_OFF, RX_HUNT, RX_SHIFT} rx_st_t;

  rx_st_t           st;
  logic [CNT_W-1:0] cnt, pos, last_pos;
  logic [TO_W-1:0]  to_cnt;
  logic             long_q, in_crc, sample;
  logic [SR_W-1:0]  sr_next;
  logic [6:0]       crc;

  assign pos      = (st == RX_HUNT) ? '0 : cnt;
  assign in_crc   = long_q ? ((pos >= CNT_W'(8)) && (pos < CNT_W'(SR_W)))
                           : (pos < CNT_W'(HDR_W));
  assign last_pos = long_q ? CNT_W'(LONG_LEN - 1) : CNT_W'(SHORT_LEN - 1);
  assign sample   = tick && (((st == RX_HUNT) && !line_in) || (st == RX_SHIFT));
  assign sr_next  = {frame[SR_W-2:0], line_in};

  sdc_crc7 i_crc (
    .clk   (clk),
    .rst   (rst),
    .clr   (arm),
    .upd   (sample && in_crc),
    .shift (1'b0),
    .din   (line_in),
    .crc   (crc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= RX_OFF;
      cnt      <= '0;
      to_cnt   <= '0;
      long_q   <= 1'b0;
      frame    <= '0;
      done_ok  <= 1'b0;
      done_crc <= 1'b0;
      done_tmo <= 1'b0;
    end else begin
      done_ok  <= 1'b0;
      done_crc <= 1'b0;
      done_tmo <= 1'b0;
      case (st)
        RX_OFF: begin
          if (arm) begin
            st     <= RX_HUNT;
            to_cnt <= '0;
            long_q <= long_mode;
          end
        end
        RX_HUNT: begin
          if (tick) begin
            if (!line_in) begin
              st    <= RX_SHIFT;
              cnt   <= CNT_W'(1);
              frame <= sr_next;
            end else if (to_cnt == TO_W'(TIMEOUT - 1)) begin
              st       <= RX_OFF;
              done_tmo <= 1'b1;
            end else begin
              to_cnt <= to_cnt + 1'b1;
            end
          end
        end
        RX_SHIFT: begin
          if (tick) begin
            frame <= sr_next;
            cnt   <= cnt + 1'b1;
            if (cnt == last_pos) begin
              st <= RX_OFF;
              if (sr_next[7:1] == crc) done_ok  <= 1'b1;
              else                     done_crc <= 1'b1;
            end
          end
        end
        default: st <= RX_OFF;
      endcase
    end
  end
endmodule

// File: rtl/sdc_cmd_engine.sv
module sdc_cmd_engine
  import sdc_cmd_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int IDX_W        = 6,
  parameter int RESP_WORDS   = 4,
  parameter int RESP_TIMEOUT = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              card_tick,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              cmd_out,
  output logic              cmd_oe,
  input  logic              cmd_in
);
  localparam int HDR_W    = 2 + IDX_W + DATA_W;
  localparam int SR_W     = RESP_WORDS * DATA_W;
  localparam int WAIT_BIT = IDX_W;
  localparam int LONG_BIT = IDX_W + 1;
  localparam int GO_BIT   = IDX_W + 2;
  localparam int RIDX_W   = $clog2(RESP_WORDS);

  seq_st_t           st_q;
  logic [DATA_W-1:0] arg_q;
  logic              wait_q, long_q;
  logic [NFLAG-1:0]  status_q, set_vec, clr_vec;
  logic              launch, tx_done, rx_ok, rx_crc, rx_tmo, capture;
  logic [SR_W-1:0]   rx_frame;
  logic [DATA_W-1:0] resp_w [RESP_WORDS];

  assign launch = reg_wr && (reg_addr == A_CMD) && reg_wdata[GO_BIT] &&
                  (st_q == ST_IDLE);

  sdc_cmd_tx #(.HDR_W(HDR_W)) i_tx (
    .clk      (clk),
    .rst      (rst),
    .tick     (card_tick),
    .start    (launch),
    .hdr      ({1'b0, 1'b1, reg_wdata[IDX_W-1:0], arg_q}),
    .line_out (cmd_out),
    .line_oe  (cmd_oe),
    .done     (tx_done)
  );

  sdc_cmd_rx #(
    .DATA_W  (DATA_W),
    .WORDS   (RESP_WORDS),
    .HDR_W   (HDR_W),
    .TIMEOUT (RESP_TIMEOUT)
  ) i_rx (
    .clk       (clk),
    .rst       (rst),
    .tick      (card_tick),
    .arm       (tx_done && wait_q),
    .long_mode (long_q),
    .line_in   (cmd_in),
    .done_ok   (rx_ok),
    .done_crc  (rx_crc),
    .done_tmo  (rx_tmo),
    .frame     (rx_frame)
  );

  always_comb begin
    set_vec         = '0;
    set_vec[F_SENT] = tx_done && !wait_q;
    set_vec[F_REND] = rx_ok;
    set_vec[F_TMO]  = rx_tmo;
    set_vec[F_CRC]  = rx_crc;
    clr_vec = (reg_wr && (reg_addr == A_STAT)) ? reg_wdata[NFLAG-1:0] : '0;
  end

  assign capture = rx_ok || rx_crc;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      arg_q    <= '0;
      wait_q   <= 1'b0;
      long_q   <= 1'b0;
      status_q <= '0;
    end else begin
      status_q <= (status_q & ~clr_vec) | set_vec;
      if (reg_wr && (reg_addr == A_ARG))
        arg_q <= reg_wdata;
      case (st_q)
        ST_IDLE: if (launch) begin
          st_q   <= ST_SEND;
          wait_q <= reg_wdata[WAIT_BIT];
          long_q <= reg_wdata[LONG_BIT];
        end
        ST_SEND: if (tx_done)
          st_q <= wait_q ? ST_RESP : ST_IDLE;
        ST_RESP: if (rx_ok || rx_crc || rx_tmo)
          st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  for (genvar w = 0; w < RESP_WORDS; w++) begin : g_rsp
    logic [DATA_W-1:0] word_q;
    always_ff @(posedge clk) begin
      if (rst)
        word_q <= '0;
      else if (capture) begin
        if (long_q)
          word_q <= rx_frame[SR_W-1-w*DATA_W -: DATA_W];
        else if (w == 0)
          word_q <= rx_frame[HDR_W-1 -: DATA_W];
      end
    end
    assign resp_w[w] = word_q;
  end

  always_ff @(posedge clk) begin
    if (rst)
      rd_data <= '0;
    else if (rd_addr == A_STAT)
      rd_data <= {{(DATA_W-NFLAG){1'b0}}, status_q};
    else if (rd_addr[ADDR_W-1])
      rd_data <= resp_w[rd_addr[RIDX_W-1:0]];
    else
      rd_data <= '0;
  end
endmodule

// File: rtl/sdc_cmd_engine_chk.sv
module sdc_cmd_engine_chk
  import sdc_cmd_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              cmd_oe,
  input logic              cmd_out,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input seq_st_t           st_q,
  input logic [NFLAG-1:0]  status_q,
  input logic [NFLAG-1:0]  set_vec
);
  AST_LINE_FREE_IDLE: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE) |-> !cmd_oe); // R11

  AST_LINE_FREE_RESP: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RESP) |-> !cmd_oe); // R11

  AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(cmd_oe) |-> !cmd_out); // R2

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && (reg_addr == A_STAT)) |=>
      ((status_q & $past(status_q)) == $past(status_q))); // R9

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    $onehot0(set_vec)); // R8

  AST_BUSY_CMD_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && (reg_addr == A_CMD) && (st_q == ST_RESP)) |=> (st_q != ST_SEND)); // R10
endmodule

bind sdc_cmd_engine sdc_cmd_engine_chk i_chk (
  .clk      (clk),
  .rst      (rst),
  .cmd_oe   (cmd_oe),
  .cmd_out  (cmd_out),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .st_q     (st_q),
  .status_q (status_q),
  .set_vec  (set_vec)
);

// File: tb/test_sdc_cmd_engine.sv
module test_sdc_cmd_engine;
  localparam int CLK_P    = 10;
  localparam int TICK_DIV = 3;
  localparam int TMO      = 64;
  localparam int WD_CYC   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        card_tick = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        cmd_out, cmd_oe, cmd_in;
  logic        card_drv = 1'b1;
  logic        saw_oe = 1'b0;
  logic [1:0]  tdiv = '0;
  logic [31:0] exp_rsp [4];
  int          n_tests = 0;
  int          n_fail = 0;

  assign cmd_in = cmd_oe ? cmd_out : card_drv;

  sdc_cmd_engine i_sdc_cmd_engine (
    .clk(clk), .rst(rst), .card_tick(card_tick),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .cmd_out(cmd_out), .cmd_oe(cmd_oe), .cmd_in(cmd_in)
  );

  always #(CLK_P/2) clk = ~clk;

  always @(negedge clk) begin
    tdiv      <= (tdiv == 2'(TICK_DIV - 1)) ? 2'd0 : tdiv + 2'd1;
    card_tick <= (tdiv == 2'(TICK_DIV - 1));
  end

  always @(posedge clk) if (cmd_oe) saw_oe <= 1'b1;

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    summary();
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] crc_bits(input logic [135:0] v, input int hi, input int lo);
    logic [6:0] c = '0;
    for (int i = hi; i >= lo; i--) begin
      logic fb = c[6] ^ v[i];
      c = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    end
    return c;
  endfunction

  task automatic next_tick();
    @(posedge clk);
    while (!card_tick) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic check_resp(input string tag);
    logic [31:0] d;
    for (int w = 0; w < 4; w++) begin
      rd(3'(4 + w), d);
      check(tag, {32'd0, d}, {32'd0, exp_rsp[w]});
    end
  endtask

  // kind: 0 none, 1 short, 2 long; lng_only: long bit set without wait bit
  task automatic run_cmd(input logic [5:0] idx, input logic [31:0] arg, input int kind,
                         input bit lng_only, input int delay, input bit bad,
                         input bit poke, input logic [127:0] payload);
    logic [39:0]  hdr;
    logic [47:0]  exp_f, got_f;
    logic [135:0] rf;
    logic [31:0]  st;
    logic [3:0]   exp_st;
    int           n, guard;
    bit           wt, lg;
    wr(3'd2, 32'hF);
    wt = (kind != 0);
    lg = (kind == 2) || lng_only;
    wr(3'd0, arg);
    wr(3'd1, {23'd0, 1'b1, lg, wt, idx});
    hdr   = {2'b01, idx, arg};
    exp_f = {hdr, crc_bits({96'd0, hdr}, 39, 0), 1'b1};
    guard = 0;
    while (!cmd_oe && guard < 20) begin next_tick(); guard++; end
    got_f[47] = cmd_out;
    for (int i = 46; i >= 0; i--) begin
      next_tick();
      got_f[i] = cmd_out;
      if (poke && i == 20) wr(3'd1, {23'd0, 1'b1, 2'b00, ~idx});
    end
    check(poke ? "R10 frame unchanged" : "R2 frame", {16'd0, got_f}, {16'd0, exp_f});
    next_tick();
    check("R11 line released", {63'd0, cmd_oe}, 64'd0);
    if (kind != 0) begin
      repeat (delay) next_tick();
      if (delay < TMO) begin
        if (kind == 1) begin
          rf = '0;
          rf[47:8] = {2'b00, idx, payload[31:0]};
          rf[7:0]  = {crc_bits(rf, 47, 8), 1'b1};
          n = 48;
        end else begin
          rf = {8'h3F, payload[119:0], 8'h00};
          rf[7:0] = {crc_bits(rf, 127, 8), 1'b1};
          n = 136;
        end
        if (bad) rf[1] = ~rf[1];
        for (int i = n - 1; i >= 0; i--) begin
          card_drv = rf[i];
          next_tick();
        end
        card_drv = 1'b1;
        if (kind == 1) exp_rsp[0] = rf[39:8];
        else for (int w = 0; w < 4; w++) exp_rsp[w] = rf[127 - 32*w -: 32];
      end
    end
    repeat (4) @(negedge clk);
    if (kind == 0)          exp_st = 4'b0001;
    else if (delay >= TMO)  exp_st = 4'b0100;
    else if (bad)           exp_st = 4'b1000;
    else                    exp_st = 4'b0010;
    rd(3'd2, st);
    check(kind == 0 ? "R4 status" : (delay >= TMO ? "R7 status" :
          (bad ? "R8 status" : (kind == 1 ? "R5 status" : "R6 status"))),
          {32'd0, st}, {60'd0, exp_st});
    check_resp(kind == 2 ? "R6 words" : (delay >= TMO ? "R7 words" : "R5 words"));
    if (poke) begin
      saw_oe = 1'b0;
      repeat (10) next_tick();
      check("R10 no second frame", {63'd0, saw_oe}, 64'd0);
    end
  endtask

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    for (int w = 0; w < 4; w++) exp_rsp[w] = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 oe", {63'd0, cmd_oe}, 64'd0);
    check("R1 out", {63'd0, cmd_out}, 64'd1);
    rd(3'd2, d);
    check("R1 status", {32'd0, d}, 64'd0);
    check_resp("R1 words");

    // R3: go bit clear sends nothing
    wr(3'd0, 32'hDEADBEEF);
    saw_oe = 1'b0;
    wr(3'd1, {23'd0, 1'b0, 2'b01, 6'd17});
    repeat (20) next_tick();
    check("R3 no launch", {63'd0, saw_oe}, 64'd0);
    rd(3'd2, d);
    check("R3 no status", {32'd0, d}, 64'd0);

    run_cmd(6'd0,  32'h0,        0, 1'b0, 0, 1'b0, 1'b0, '0);           // R4
    run_cmd(6'd63, 32'hFFFFFFFF, 0, 1'b1, 0, 1'b0, 1'b0, '0);           // R4 long bit only
    run_cmd(6'd8,  32'h000001AA, 1, 1'b0, 0, 1'b0, 1'b0, 128'h12345678); // R5
    run_cmd(6'd55, 32'h0,        1, 1'b0, TMO-1, 1'b0, 1'b0, 128'hCAFEF00D); // R7 edge accepted
    run_cmd(6'd13, 32'h5,        1, 1'b0, TMO, 1'b0, 1'b0, 128'h0);     // R7 timeout
    run_cmd(6'd2,  32'h0,        2, 1'b0, 3, 1'b0, 1'b0,
            128'h0123456789ABCDEF_FEDCBA9876543210);                    // R6
    run_cmd(6'd9,  32'h00010000, 2, 1'b0, 1, 1'b1, 1'b0,
            128'hA5A5A5A5_5A5A5A5A_0F0F0F0F_F0F0F0F0);                  // R8 long
    run_cmd(6'd7,  32'h00020000, 1, 1'b0, 2, 1'b1, 1'b0, 128'h87654321); // R8 short
    run_cmd(6'd12, 32'h0,        0, 1'b0, 0, 1'b0, 1'b1, '0);           // R10

    // R9: sticky flags, selective clear
    run_cmd(6'd3, 32'h0, 1, 1'b0, 0, 1'b0, 1'b0, 128'h00000B00);
    wr(3'd2, 32'h0);
    rd(3'd2, d);
    check("R9 zero write keeps", {32'd0, d}, 64'h2);
    wr(3'd2, 32'h1);
    rd(3'd2, d);
    check("R9 other bit keeps", {32'd0, d}, 64'h2);
    repeat (30) @(negedge clk);
    rd(3'd2, d);
    check("R9 still set", {32'd0, d}, 64'h2);
    wr(3'd2, 32'h2);
    rd(3'd2, d);
    check("R9 cleared", {32'd0, d}, 64'h0);

    // random mix
    for (int it = 0; it < 36; it++) begin
      int k  = $urandom_range(0, 2);
      int dl = ($urandom_range(0, 9) == 0) ? TMO : $urandom_range(0, 20);
      bit bd = ($urandom_range(0, 5) == 0);
      run_cmd(6'($urandom), $urandom, k, 1'b0, dl, bd, 1'b0,
              {$urandom, $urandom, $urandom, $urandom});
    end
    summary();
  end
endmodule